// File: doc/BRIEF.md
# Instruction-Indexed Stride Prefetcher with Duplicate Filter

This block watches the load and store stream of a first-level data cache and predicts, for each memory instruction, the constant distance between its successive data addresses. Training runs on a retirement port, so each instruction's addresses arrive in program order. Issuing runs on a separate cache-access port. When an access misses, or hits a line that an earlier prefetch brought in, the block looks up that instruction's stride. If the stride is well established, the block requests the line sixteen strides ahead.

The block keeps a fully associative table of 64 instruction entries and evicts the least recently trained entry. A prefetch is requested only when the confidence counter is saturated. Before a request leaves, it passes a small FIFO of recently requested line numbers, which removes requests the block has already made. The output is a single line-aligned prefetch address, which is valid for one cycle.

Top module: `stride_pf_top`

## Requirements
- R1: After reset the table and the filter are empty, `pfValid` is 0, and no access produces a prefetch until its instruction address has been trained.
- R2: A retirement whose instruction address is not in the table allocates an entry with last address = the retired address, stride 0 and confidence 0. Seventeen retirements at a constant non-zero stride (the allocating one included) are needed before prefetching starts; after sixteen there is none.
- R3: On a retirement that hits, confidence increments if the retired address equals last address plus stride and otherwise clears to 0. The stride then becomes retired address minus last address, and the last address becomes the retired address.
- R4: Confidence is 4 bits wide and saturates at 15; more matching retirements keep it at 15.
- R5: When an access carries `accMiss` or `accPfHit`, its instruction address hits, the stride is non-zero and confidence is 15, `pfValid` is 1 in the cycle after the access. `pfAddr` is then (access address + 16 × stride) modulo 2^32 with bits [5:0] cleared (64-byte lines). Negative strides are two's complement.
- R6: An access with both `accMiss` and `accPfHit` low, or with `accValid` low, never produces a prefetch.
- R7: A request whose target line (address bits [31:6]) matches a line in the filter is dropped, including when it comes from a different byte of the same line.
- R8: The filter records each issued line in a 16-entry FIFO that overwrites its oldest entry. A line stays filtered through 15 later issues and can be issued again after the 16th.
- R9: When a retirement and an access address the same entry in one cycle, the access sees the entry as it was before that retirement updates it.
- R10: When all 64 entries are in use, allocation evicts the entry that was least recently allocated or trained. Accesses do not change this order. At most one entry holds a given instruction address.
- R11: An entry with stride 0 never prefetches, even at confidence 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| retValid | input | 1 | A memory instruction retires this cycle |
| retPc | input | 32 | Instruction address of the retiring access |
| retAddr | input | 32 | Data address of the retiring access |
| accValid | input | 1 | A cache access is presented this cycle |
| accPc | input | 32 | Instruction address of the cache access |
| accAddr | input | 32 | Data address of the cache access |
| accMiss | input | 1 | The access missed the cache |
| accPfHit | input | 1 | The access hit a line brought in by a prefetch |
| pfValid | output | 1 | Prefetch request valid |
| pfAddr | output | 32 | Line-aligned prefetch address |

## Verification
Training and lookup share the table, and both can touch one entry in the same cycle. The bench provokes this in two directions. In the first, a saturated entry retires with a mismatching address while an access to it misses; the access must still issue with the old stride, and the next access must not issue. In the second, an entry one match short of full confidence retires its matching address while an access arrives; that access must not issue, and the following access must. The expected addresses come from the stride arithmetic in the bench, and the filter sweep counts exactly fifteen and then sixteen intervening issues.

// File: rtl/spf_pkg.sv
package spf_pkg;
  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic train;   // update the hitting entry from the retirement
    logic alloc;   // write the victim entry from the retirement
    logic issue;   // emit a prefetch and record its line
  } spfCtl_t;
endpackage

// File: rtl/spf_ctrl.sv
module spf_ctrl (
  input  logic             retValid,
  input  logic             retHit,
  input  logic             accValid,
  input  logic             accMiss,
  input  logic             accPfHit,
  input  logic             accHit,
  input  logic             accStrideNz,
  input  logic             accConfFull,
  input  logic             filtMatch,
  output spf_pkg::spfCtl_t ctl
);
  logic accTrig;

  always_comb begin
    accTrig   = accValid && (accMiss || accPfHit);
    ctl.train = retValid && retHit;
    ctl.alloc = retValid && !retHit;
    ctl.issue = accTrig && accHit && accStrideNz && accConfFull && !filtMatch;
  end
endmodule

// File: rtl/spf_dpath.sv
module spf_dpath #(
  parameter int PC_W       = 32,
  parameter int ADDR_W     = 32,
  parameter int ENTRIES    = 64,
  parameter int CONF_W     = 4,
  parameter int DIST_SHIFT = 4,
  parameter int LINE_SHIFT = 6,
  parameter int FILT_DEPTH = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  spf_pkg::spfCtl_t     ctl,
  input  logic [PC_W-1:0]      retPc,
  input  logic [ADDR_W-1:0]    retAddr,
  input  logic [PC_W-1:0]      accPc,
  input  logic [ADDR_W-1:0]    accAddr,
  output logic                 retHit,
  output logic [ENTRIES-1:0]   retHitVec,
  output logic                 accHit,
  output logic                 accStrideNz,
  output logic                 accConfFull,
  output logic                 filtMatch,
  output logic                 pfValid,
  output logic [ADDR_W-1:0]    pfAddr
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int FIDX_W = $clog2(FILT_DEPTH);
  localparam int LINE_W = ADDR_W - LINE_SHIFT;
  localparam logic [CONF_W-1:0] CONF_MAX = {CONF_W{1'b1}};
  localparam logic [IDX_W-1:0]  OLDEST   = IDX_W'(ENTRIES - 1);
  localparam logic [FIDX_W-1:0] FLAST    = FIDX_W'(FILT_DEPTH - 1);

  // Stride table
  logic              validQ  [ENTRIES];
  logic [PC_W-1:0]   tagQ    [ENTRIES];
  logic [ADDR_W-1:0] lastQ   [ENTRIES];
  logic [ADDR_W-1:0] strideQ [ENTRIES];
  logic [CONF_W-1:0] confQ   [ENTRIES];
  logic [IDX_W-1:0]  ageQ    [ENTRIES];

  // Recent-line filter
  logic              fValidQ [FILT_DEPTH];
  logic [LINE_W-1:0] fLineQ  [FILT_DEPTH];
  logic [FIDX_W-1:0] fWrPtrQ;

  logic [ENTRIES-1:0]    accHitVec;
  logic [ENTRIES-1:0]    victimVec;
  logic [FILT_DEPTH-1:0] fHitVec;
  logic [IDX_W-1:0]      retIdx, victimIdx, touchIdx, accIdx;
  logic [IDX_W-1:0]      touchAge;
  logic                  touch;
  logic [ADDR_W-1:0]     accStride, retExpect, target;
  logic [LINE_W-1:0]     tgtLine;

  genvar gi;
  generate
    for (gi = 0; gi < ENTRIES; gi++) begin : g_cam
      assign retHitVec[gi] = validQ[gi] && (tagQ[gi] == retPc);
      assign accHitVec[gi] = validQ[gi] && (tagQ[gi] == accPc);
      assign victimVec[gi] = (ageQ[gi] == OLDEST);
    end
    for (gi = 0; gi < FILT_DEPTH; gi++) begin : g_filt
      assign fHitVec[gi] = fValidQ[gi] && (fLineQ[gi] == tgtLine);
    end
  endgenerate

  always_comb begin
    retIdx    = '0;
    victimIdx = '0;
    accIdx    = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (retHitVec[i]) retIdx    = retIdx    | IDX_W'(i);
      if (victimVec[i]) victimIdx = victimIdx | IDX_W'(i);
      if (accHitVec[i]) accIdx    = accIdx    | IDX_W'(i);
    end
  end

  always_comb begin
    retHit      = |retHitVec;
    accHit      = |accHitVec;
    accStride   = strideQ[accIdx];
    accStrideNz = (accStride != '0);
    accConfFull = (confQ[accIdx] == CONF_MAX);
    target      = accAddr + (accStride << DIST_SHIFT);
    tgtLine     = target[ADDR_W-1:LINE_SHIFT];
    filtMatch   = |fHitVec;
    retExpect   = lastQ[retIdx] + strideQ[retIdx];
    touch       = ctl.train || ctl.alloc;
    touchIdx    = ctl.alloc ? victimIdx : retIdx;
    touchAge    = ageQ[touchIdx];
  end

  // Table write and recency ranking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        validQ[i]  <= 1'b0;
        tagQ[i]    <= '0;
        lastQ[i]   <= '0;
        strideQ[i] <= '0;
        confQ[i]   <= '0;
        ageQ[i]    <= IDX_W'(i);
      end
    end else begin
      if (ctl.train) begin
        if (retAddr == retExpect) begin
          if (confQ[retIdx] != CONF_MAX) confQ[retIdx] <= confQ[retIdx] + 1'b1;
        end else begin
          confQ[retIdx] <= '0;
        end
        strideQ[retIdx] <= retAddr - lastQ[retIdx];
        lastQ[retIdx]   <= retAddr;
      end
      if (ctl.alloc) begin
        validQ[victimIdx]  <= 1'b1;
        tagQ[victimIdx]    <= retPc;
        lastQ[victimIdx]   <= retAddr;
        strideQ[victimIdx] <= '0;
        confQ[victimIdx]   <= '0;
      end
      if (touch) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (IDX_W'(i) == touchIdx)   ageQ[i] <= '0;
          else if (ageQ[i] < touchAge) ageQ[i] <= ageQ[i] + 1'b1;
        end
      end
    end
  end

  // Filter FIFO and output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < FILT_DEPTH; j++) begin
        fValidQ[j] <= 1'b0;
        fLineQ[j]  <= '0;
      end
      fWrPtrQ <= '0;
      pfValid <= 1'b0;
      pfAddr  <= '0;
    end else begin
      pfValid <= ctl.issue;
      if (ctl.issue) begin
        fValidQ[fWrPtrQ] <= 1'b1;
        fLineQ[fWrPtrQ]  <= tgtLine;
        fWrPtrQ          <= (fWrPtrQ == FLAST) ? '0 : fWrPtrQ + 1'b1;
        pfAddr           <= {tgtLine, {LINE_SHIFT{1'b0}}};
      end
    end
  end
endmodule

// File: rtl/stride_pf_top.sv
module stride_pf_top #(
  parameter int PC_W       = 32,
  parameter int ADDR_W     = 32,
  parameter int ENTRIES    = 64,
  parameter int CONF_W     = 4,
  parameter int DIST_SHIFT = 4,
  parameter int LINE_SHIFT = 6,
  parameter int FILT_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              retValid,
  input  logic [PC_W-1:0]   retPc,
  input  logic [ADDR_W-1:0] retAddr,
  input  logic              accValid,
  input  logic [PC_W-1:0]   accPc,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accMiss,
  input  logic              accPfHit,
  output logic              pfValid,
  output logic [ADDR_W-1:0] pfAddr
);
  spf_pkg::spfCtl_t   ctl;
  logic               retHit, accHit, accStrideNz, accConfFull, filtMatch;
  logic [ENTRIES-1:0] retHitVec;

  spf_ctrl u_ctrl (
    .retValid    (retValid),
    .retHit      (retHit),
    .accValid    (accValid),
    .accMiss     (accMiss),
    .accPfHit    (accPfHit),
    .accHit      (accHit),
    .accStrideNz (accStrideNz),
    .accConfFull (accConfFull),
    .filtMatch   (filtMatch),
    .ctl         (ctl)
  );

  spf_dpath #(
    .PC_W(PC_W), .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .CONF_W(CONF_W),
    .DIST_SHIFT(DIST_SHIFT), .LINE_SHIFT(LINE_SHIFT), .FILT_DEPTH(FILT_DEPTH)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .retPc       (retPc),
    .retAddr     (retAddr),
    .accPc       (accPc),
    .accAddr     (accAddr),
    .retHit      (retHit),
    .retHitVec   (retHitVec),
    .accHit      (accHit),
    .accStrideNz (accStrideNz),
    .accConfFull (accConfFull),
    .filtMatch   (filtMatch),
    .pfValid     (pfValid),
    .pfAddr      (pfAddr)
  );
endmodule

// File: rtl/stride_pf_chk.sv
module stride_pf_chk #(
  parameter int ADDR_W     = 32,
  parameter int ENTRIES    = 64,
  parameter int LINE_SHIFT = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               accValid,
  input logic               accMiss,
  input logic               accPfHit,
  input logic               pfValid,
  input logic [ADDR_W-1:0]  pfAddr,
  input logic [ENTRIES-1:0] retHitVec
);
  // R5
  pf_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    pfValid |-> $past(accValid && (accMiss || accPfHit)));

  // R6
  no_trig_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!accValid || !(accMiss || accPfHit)) |=> !pfValid);

  // R5
  pf_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    pfValid |-> (pfAddr[LINE_SHIFT-1:0] == '0));

  // R7
  pf_dup_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pfValid && $past(pfValid)) |-> (pfAddr != $past(pfAddr)));

  // R10
  tag_unique_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(retHitVec));
endmodule

bind stride_pf_top stride_pf_chk #(
  .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .LINE_SHIFT(LINE_SHIFT)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .accValid  (accValid),
  .accMiss   (accMiss),
  .accPfHit  (accPfHit),
  .pfValid   (pfValid),
  .pfAddr    (pfAddr),
  .retHitVec (retHitVec)
);

// File: tb/stride_pf_top_tb.sv
module stride_pf_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        retValid = 1'b0;
  logic [31:0] retPc = '0;
  logic [31:0] retAddr = '0;
  logic        accValid = 1'b0;
  logic [31:0] accPc = '0;
  logic [31:0] accAddr = '0;
  logic        accMiss = 1'b0;
  logic        accPfHit = 1'b0;
  logic        pfValid;
  logic [31:0] pfAddr;

  int          nTests = 0;
  int          nFails = 0;
  logic        gotV;
  logic [31:0] gotA;

  always #10 clk = ~clk;

  stride_pf_top u_dut (
    .clk(clk), .rstN(rstN),
    .retValid(retValid), .retPc(retPc), .retAddr(retAddr),
    .accValid(accValid), .accPc(accPc), .accAddr(accAddr),
    .accMiss(accMiss), .accPfHit(accPfHit),
    .pfValid(pfValid), .pfAddr(pfAddr)
  );

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not finish (got timeout, expected completion)");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  // Called at a falling edge; returns at the next falling edge with outputs sampled
  task automatic step(input logic rv, input logic [31:0] rpc, input logic [31:0] ra,
                      input logic av, input logic [31:0] apc, input logic [31:0] aa,
                      input logic m, input logic ph);
    retValid = rv; retPc = rpc; retAddr = ra;
    accValid = av; accPc = apc; accAddr = aa; accMiss = m; accPfHit = ph;
    @(posedge clk);
    @(negedge clk);
    gotV = pfValid;
    gotA = pfAddr;
    retValid = 1'b0; accValid = 1'b0; accMiss = 1'b0; accPfHit = 1'b0;
  endtask

  task automatic ret(input logic [31:0] pc, input logic [31:0] a);
    step(1'b1, pc, a, 1'b0, '0, '0, 1'b0, 1'b0);
  endtask

  task automatic acc(input logic [31:0] pc, input logic [31:0] a, input logic m, input logic ph);
    step(1'b0, '0, '0, 1'b1, pc, a, m, ph);
  endtask

  task automatic train(input logic [31:0] pc, input logic [31:0] base,
                       input logic [31:0] stride, input int n);
    for (int k = 0; k < n; k++) ret(pc, base + 32'(k) * stride);
  endtask

  task automatic expectPf(input string req, input logic expV, input logic [31:0] expA);
    nTests++;
    if (gotV !== expV || (expV && gotA !== expA)) begin
      nFails++;
      $display("FAIL %s: got valid=%0b addr=%h, expected valid=%0b addr=%h",
               req, gotV, gotA, expV, expA);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  localparam logic [31:0] PA = 32'h100, PC = 32'h200, PN = 32'h300;
  localparam logic [31:0] PZ = 32'h500, PD = 32'h600;

  initial begin
    doReset();
    // R1: quiet after reset, empty table
    nTests++;
    if (pfValid !== 1'b0) begin
      nFails++;
      $display("FAIL R1: got valid=%0b, expected valid=0", pfValid);
    end
    acc(32'h400, 32'h1000, 1'b1, 1'b0);
    expectPf("R1", 1'b0, '0);

    // R2: sixteen retirements are not enough, the seventeenth is
    train(PA, 32'h10000, 32'd64, 16);
    acc(PA, 32'h20000, 1'b1, 1'b0);
    expectPf("R2", 1'b0, '0);
    ret(PA, 32'h10000 + 16 * 64);
    acc(PA, 32'h20000, 1'b1, 1'b0);
    expectPf("R5", 1'b1, 32'h20400);
    // R4: one more match must keep confidence at 15
    ret(PA, 32'h10000 + 17 * 64);
    acc(PA, 32'h30000, 1'b1, 1'b0);
    expectPf("R4", 1'b1, 32'h30400);

    // R6: trigger flags
    acc(PA, 32'h40000, 1'b0, 1'b0);
    expectPf("R6", 1'b0, '0);
    acc(PA, 32'h40000, 1'b0, 1'b1);
    expectPf("R6", 1'b1, 32'h40400);

    // R5: stride that is not a line multiple, target rounded down to its line
    train(PC, 32'h50000, 32'd24, 17);
    acc(PC, 32'h60010, 1'b1, 1'b0);
    expectPf("R5", 1'b1, 32'h60180);

    // R5: negative stride
    train(PN, 32'h90000, 32'hFFFF_FF80, 17);
    acc(PN, 32'h70000, 1'b1, 1'b0);
    expectPf("R5", 1'b1, 32'h6F800);

    // R11: zero stride never prefetches
    for (int k = 0; k < 20; k++) ret(PZ, 32'h80000);
    acc(PZ, 32'h80000, 1'b1, 1'b0);
    expectPf("R11", 1'b0, '0);

    // R3: mismatch clears confidence, then 15 matches rebuild it
    ret(PA, 32'hA0000);
    acc(PA, 32'hB0000, 1'b1, 1'b0);
    expectPf("R3", 1'b0, '0);
    for (int k = 1; k <= 15; k++) ret(PA, 32'hA0000 + 32'(k) * 64);
    acc(PA, 32'hB1000, 1'b1, 1'b0);
    expectPf("R3", 1'b0, '0);
    ret(PA, 32'hA0000 + 16 * 64);
    acc(PA, 32'hB2000, 1'b1, 1'b0);
    expectPf("R3", 1'b1, 32'hB2400);

    // R7 / R8: duplicate filter
    acc(PA, 32'hC0000, 1'b1, 1'b0);
    expectPf("R7", 1'b1, 32'hC0400);
    acc(PA, 32'hC0000, 1'b1, 1'b0);
    expectPf("R7", 1'b0, '0);
    acc(PA, 32'hC0008, 1'b1, 1'b0);
    expectPf("R7", 1'b0, '0);
    for (int k = 1; k <= 15; k++) begin
      acc(PA, 32'hC0000 + 32'(k) * 64, 1'b1, 1'b0);
      expectPf("R8", 1'b1, 32'hC0400 + 32'(k) * 64);
    end
    acc(PA, 32'hC0000, 1'b1, 1'b0);
    expectPf("R8", 1'b0, '0);
    acc(PA, 32'hC0000 + 16 * 64, 1'b1, 1'b0);
    expectPf("R8", 1'b1, 32'hC0800);
    acc(PA, 32'hC0000, 1'b1, 1'b0);
    expectPf("R8", 1'b1, 32'hC0400);

    // R9: same-cycle retire and access see the old entry
    step(1'b1, PA, 32'hD0000, 1'b1, PA, 32'hE0000, 1'b1, 1'b0);
    expectPf("R9", 1'b1, 32'hE0400);
    acc(PA, 32'hE1000, 1'b1, 1'b0);
    expectPf("R9", 1'b0, '0);
    train(PD, 32'h100000, 32'd128, 16);
    step(1'b1, PD, 32'h100000 + 16 * 128, 1'b1, PD, 32'hF0000, 1'b1, 1'b0);
    expectPf("R9", 1'b0, '0);
    acc(PD, 32'hF1000, 1'b1, 1'b0);
    expectPf("R9", 1'b1, 32'hF1800);

    // R10: least recently trained entry is evicted
    doReset();
    train(32'h1000, 32'h200000, 32'd64, 17);
    train(32'h2000, 32'h300000, 32'd64, 17);
    ret(32'h1000, 32'h200000 + 17 * 64);
    for (int k = 0; k < 62; k++) ret(32'h4000 + 32'(k) * 4, 32'h500000 + 32'(k) * 4096);
    acc(32'h1000, 32'h400000, 1'b1, 1'b0);
    expectPf("R10", 1'b1, 32'h400400);
    acc(32'h2000, 32'h410000, 1'b1, 1'b0);
    expectPf("R10", 1'b1, 32'h410400);
    ret(32'h9000, 32'h600000);
    acc(32'h2000, 32'h420000, 1'b1, 1'b0);
    expectPf("R10", 1'b0, '0);
    acc(32'h1000, 32'h430000, 1'b1, 1'b0);
    expectPf("R10", 1'b1, 32'h430400);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule